// File: doc/BRIEF.md
# Integrate-and-Fire Neuron Step Engine

This block keeps the state of a single conductance-based integrate-and-fire neuron and advances it by one discrete time step for each `start` pulse. A step takes the excitatory and inhibitory weight sums collected from the neuron's synapse column, plus an external drive term. It adds each sum into its conductance and then decays that conductance by a preloaded factor. It forms the steady-state target potential from the two conductances, the drive and an offset. It then relaxes the membrane potential toward that target by a preloaded relaxation factor. The relaxed potential is compared against the neuron's own firing threshold.

Every quantity is a 16-bit signed Q8.8 value. A single multiplier is shared across the four products of a step. Each product is rounded half-up and saturated back to 16 bits, and each sum or difference is saturated as well. After a spike the membrane potential returns to its rest value. A programmable refractory count then freezes the potential and suppresses firing for that many later steps. The per-neuron constants are loaded at initialization through a small write port.

Top module: `if_neuron_update`

## Requirements
- R1: While `rst` is high and after its release, `v_out`, `gex_out` and `gin_out` are 0, and `spike`, `busy` and `update_done` are low.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the constant selected by `cfg_addr`. The address map is 0 rest potential, 1 gain, 2 offset, 3 firing threshold, 4 excitatory decay, 5 inhibitory decay, 6 membrane relaxation, and 7 refractory length (low 8 bits). All constants reset to 0.
- R3: On each step the excitatory conductance becomes round(sat(gex + syn_ex) × excitatory decay).
- R4: On each step the inhibitory conductance becomes round(sat(gin + syn_in) × inhibitory decay).
- R5: The target is T = sat(rest + round(gain × sat(gex − gin + ext_in − offset))), using the conductances just updated. The relaxed potential is Vn = sat(T + round(sat(V − T) × relaxation)). `v_out` changes only in the cycle in which `update_done` is high.
- R6: When no refractory count is pending, `spike` is set at the end of a step exactly when Vn is strictly greater than the firing threshold. A Vn equal to the threshold does not fire.
- R7: On a spike, V becomes the rest potential and the refractory count loads the refractory length. While the count is non-zero, each step decrements it, keeps V unchanged and raises no spike. The conductances still update during these steps.
- R8: `start` is accepted only when `busy` is low. `update_done` is a single-cycle pulse whose high cycle starts at the fifth rising edge counted from the edge that accepted `start`. A `start` raised while busy is ignored.
- R9: Products are Q8.8 and rounded by adding half an LSB (0x80 before the 8-bit shift), with ties going toward +∞. Every product, sum and difference saturates to the range 0x8000..0x7FFF.
- R10: `spike` keeps its value from the end of a step until the next accepted `start` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Constant write strobe |
| cfg_addr | input | 3 | Constant select |
| cfg_wdata | input | 16 | Constant value, Q8.8 |
| start | input | 1 | Begin one time step |
| syn_ex | input | 16 | Summed excitatory weight, Q8.8 |
| syn_in | input | 16 | Summed inhibitory weight, Q8.8 |
| ext_in | input | 16 | External drive term, Q8.8 |
| busy | output | 1 | Step in progress |
| update_done | output | 1 | Step finished, one-cycle pulse |
| spike | output | 1 | Neuron fired in the last step |
| v_out | output | 16 | Membrane potential, Q8.8 |
| gex_out | output | 16 | Excitatory conductance, Q8.8 |
| gin_out | output | 16 | Inhibitory conductance, Q8.8 |

## Verification
A stimulus table drives a run of steps with mixed excitatory, inhibitory and drive inputs under fractional decay factors. This shows whether each conductance uses its own sum and factor, and whether the target takes the freshly updated conductances. The run crosses the threshold and then feeds strong drive during the refractory window, which separates correct suppression and holding of V from a refractory count that is off by one. Directed steps with all factors at zero place Vn exactly on the threshold and one LSB above it, which isolates strict from non-strict comparison. Tiny positive and negative products expose the rounding direction, and full-scale sums expose missing saturation. A start pulse issued mid-step shows whether a second, unwanted step is taken.

// File: rtl/if_neuron_update.sv
module if_neuron_update #(
  parameter int W      = 16,
  parameter int FRAC   = 8,
  parameter int REFR_W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_we,
  input  logic [2:0]   cfg_addr,
  input  logic [W-1:0] cfg_wdata,
  input  logic         start,
  input  logic [W-1:0] syn_ex,
  input  logic [W-1:0] syn_in,
  input  logic [W-1:0] ext_in,
  output logic         busy,
  output logic         update_done,
  output logic         spike,
  output logic [W-1:0] v_out,
  output logic [W-1:0] gex_out,
  output logic [W-1:0] gin_out
);
  localparam int XW = 2*W + 2;
  localparam logic signed [XW-1:0] MAXV = XW'((1 << (W-1)) - 1);
  localparam logic signed [XW-1:0] MINV = -XW'(1 << (W-1));
  localparam logic signed [XW-1:0] HALF = XW'(1 << (FRAC-1));

  typedef enum logic [2:0] {ST_IDLE, ST_EX, ST_IN, ST_TGT, ST_REL} st_t;
  st_t st;

  logic signed [W-1:0] c_rest, c_gain, c_off, c_thr, c_dex, c_din, c_rel;
  logic [REFR_W-1:0]   c_refr, refr_cnt;
  logic signed [W-1:0] gex, gin, v, tgt;
  logic signed [W-1:0] l_ex, l_in, l_drv;

  function automatic logic signed [W-1:0] sat(input logic signed [XW-1:0] x);
    if (x > MAXV)      sat = MAXV[W-1:0];
    else if (x < MINV) sat = MINV[W-1:0];
    else               sat = x[W-1:0];
  endfunction

  function automatic logic signed [XW-1:0] ext(input logic signed [W-1:0] x);
    ext = XW'(x);
  endfunction

  logic signed [W-1:0]  mul_a, mul_b, mul_q, v_next;
  logic signed [XW-1:0] mul_p;

  always_comb begin
    mul_a = '0;
    mul_b = '0;
    unique case (st)
      ST_EX:  begin mul_a = sat(ext(gex) + ext(l_ex)); mul_b = c_dex; end
      ST_IN:  begin mul_a = sat(ext(gin) + ext(l_in)); mul_b = c_din; end
      ST_TGT: begin
        mul_a = sat(ext(gex) - ext(gin) + ext(l_drv) - ext(c_off));
        mul_b = c_gain;
      end
      ST_REL: begin mul_a = sat(ext(v) - ext(tgt)); mul_b = c_rel; end
      default: ;
    endcase
  end

  assign mul_p  = (ext(mul_a) * ext(mul_b) + HALF) >>> FRAC;
  assign mul_q  = sat(mul_p);
  assign v_next = sat(ext(tgt) + ext(mul_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      c_rest <= '0; c_gain <= '0; c_off <= '0; c_thr <= '0;
      c_dex  <= '0; c_din  <= '0; c_rel <= '0; c_refr <= '0;
    end else if (cfg_we) begin
      unique case (cfg_addr)
        3'd0: c_rest <= cfg_wdata;
        3'd1: c_gain <= cfg_wdata;
        3'd2: c_off  <= cfg_wdata;
        3'd3: c_thr  <= cfg_wdata;
        3'd4: c_dex  <= cfg_wdata;
        3'd5: c_din  <= cfg_wdata;
        3'd6: c_rel  <= cfg_wdata;
        3'd7: c_refr <= cfg_wdata[REFR_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      gex <= '0; gin <= '0; v <= '0; tgt <= '0;
      l_ex <= '0; l_in <= '0; l_drv <= '0;
      refr_cnt <= '0; spike <= 1'b0; update_done <= 1'b0;
    end else begin
      update_done <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          l_ex <= syn_ex; l_in <= syn_in; l_drv <= ext_in;
          spike <= 1'b0;
          st <= ST_EX;
        end
        ST_EX:  begin gex <= mul_q; st <= ST_IN; end
        ST_IN:  begin gin <= mul_q; st <= ST_TGT; end
        ST_TGT: begin tgt <= sat(ext(c_rest) + ext(mul_q)); st <= ST_REL; end
        ST_REL: begin
          if (refr_cnt != '0) begin
            refr_cnt <= refr_cnt - 1'b1;
          end else if (v_next > c_thr) begin
            spike <= 1'b1;
            v <= c_rest;
            refr_cnt <= c_refr;
          end else begin
            v <= v_next;
          end
          update_done <= 1'b1;
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (st != ST_IDLE);
  assign v_out   = v;
  assign gex_out = gex;
  assign gin_out = gin;
endmodule

module if_neuron_update_chk #(parameter int W = 16) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         update_done,
  input logic         spike,
  input logic [W-1:0] v_out
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    update_done |=> !update_done);
  // R8
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R5
  v_change_chk: assert property (@(posedge clk) disable iff (rst)
    (v_out != $past(v_out)) |-> update_done);
  // R6
  spike_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(spike) |-> update_done);
  // R10
  spike_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (spike && !(start && !busy)) |=> spike);
endmodule

bind if_neuron_update if_neuron_update_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy),
  .update_done(update_done), .spike(spike), .v_out(v_out)
);

// File: tb/if_neuron_update_tb.sv
`timescale 1ns/1ps
module if_neuron_update_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0, syn_ex = '0, syn_in = '0, ext_in = '0;
  logic start = 1'b0;
  logic busy, update_done, spike;
  logic [15:0] v_out, gex_out, gin_out;

  if_neuron_update u_dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;
  int m_rest, m_gain, m_off, m_thr, m_dex, m_din, m_rel, m_refr;
  int m_gex, m_gin, m_v, m_cnt, m_spk;
  int n_spikes = 0, n_blocked = 0;

  localparam logic [47:0] STIM [8] = '{
    {16'h0200, 16'h0080, 16'h0000},
    {16'h0100, 16'h0200, 16'h0100},
    {16'h0300, 16'h0040, 16'h0200},
    {16'h0400, 16'h0000, 16'h0800},
    {16'h0400, 16'h0000, 16'h0A00},
    {16'h0000, 16'h0000, 16'h0C00},
    {16'h0200, 16'h0100, 16'h0C00},
    {16'hFF00, 16'h0300, 16'hFE00}
  };

  function automatic int sat(input int x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  function automatic int mulq(input int a, input int b);
    return sat((a * b + 128) >>> 8);
  endfunction

  function automatic int s16(input logic [15:0] x);
    return int'($signed(x));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      0: m_rest = s16(16'(d)); 1: m_gain = s16(16'(d));
      2: m_off  = s16(16'(d)); 3: m_thr  = s16(16'(d));
      4: m_dex  = s16(16'(d)); 5: m_din  = s16(16'(d));
      6: m_rel  = s16(16'(d)); default: m_refr = d & 255;
    endcase
  endtask

  task automatic model(input int ex, input int inh, input int drv);
    int t, vn;
    m_gex = mulq(sat(m_gex + ex), m_dex);
    m_gin = mulq(sat(m_gin + inh), m_din);
    t  = sat(m_rest + mulq(sat(m_gex - m_gin + drv - m_off), m_gain));
    vn = sat(t + mulq(sat(m_v - t), m_rel));
    m_spk = 0;
    if (m_cnt != 0) begin m_cnt--; n_blocked++; end
    else if (vn > m_thr) begin m_spk = 1; m_v = m_rest; m_cnt = m_refr; n_spikes++; end
    else m_v = vn;
  endtask

  task automatic step(input logic [15:0] ex, input logic [15:0] inh,
                      input logic [15:0] drv, input bit extra, output int n);
    @(negedge clk);
    syn_ex = ex; syn_in = inh; ext_in = drv; start = 1'b1;
    @(negedge clk);
    start = 1'b0; n = 1;
    while (!update_done && n < 20) begin
      @(negedge clk);
      n++;
      if (extra && n == 2) begin start = 1'b1; syn_ex = 16'h1000; end
      if (extra && n == 3) start = 1'b0;
    end
    model(s16(ex), s16(inh), s16(drv));
  endtask

  task automatic check_state(input string tag);
    chk({tag, " gex"}, s16(gex_out), m_gex);
    chk({tag, " gin"}, s16(gin_out), m_gin);
    chk({tag, " v"}, s16(v_out), m_v);
    chk({tag, " spike"}, int'(spike), m_spk);
  endtask

  bit finished = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    m_gex = 0; m_gin = 0; m_v = 0; m_cnt = 0; m_spk = 0;
    m_rest = 0; m_gain = 0; m_off = 0; m_thr = 0;
    m_dex = 0; m_din = 0; m_rel = 0; m_refr = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 v", int'(v_out), 0);
    chk("R1 gex", int'(gex_out), 0);
    chk("R1 flags", int'({spike, busy, update_done}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", int'({spike, busy, update_done, v_out}), 0);

    // R2 constants through the write port
    wr(0, 16'h0000); wr(1, 16'h0100); wr(2, 16'h0000); wr(3, 16'h0400);
    wr(4, 16'h00C0); wr(5, 16'h0080); wr(6, 16'h0080); wr(7, 2);

    // R3 R4 R5 R6 R7 table walk
    foreach (STIM[i]) begin
      step(STIM[i][47:32], STIM[i][31:16], STIM[i][15:0], 1'b0, n);
      check_state($sformatf("R3/R4/R5/R6/R7 row%0d", i));
    end
    chk("R6 spike occurred in table", int'(n_spikes > 0), 1);
    chk("R7 refractory step occurred", int'(n_blocked > 0), 1);

    // R8 latency and pulse width
    step(16'h0000, 16'h0000, 16'h0000, 1'b0, n);
    chk("R8 latency", n, 5);
    @(negedge clk);
    chk("R8 single pulse", int'(update_done), 0);
    check_state("R8 state");

    // R2 R6 exact threshold: all factors zero
    wr(4, 0); wr(5, 0); wr(6, 0); wr(7, 0); wr(0, 16'h0100); wr(3, 16'h0300);
    for (int k = 0; k < 3; k++) step(16'h0000, 16'h0000, 16'h0000, 1'b0, n);
    step(16'h0000, 16'h0000, 16'h0200, 1'b0, n);
    chk("R6 equal no spike", int'(spike), 0);
    chk("R6 equal v", s16(v_out), 16'h0300);
    // R10 spike holds after step
    step(16'h0000, 16'h0000, 16'h0201, 1'b0, n);
    chk("R6 above fires", int'(spike), 1);
    chk("R7 v to rest", s16(v_out), 16'h0100);
    repeat (3) @(negedge clk);
    chk("R10 spike held", int'(spike), 1);
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    chk("R10 cleared on start", int'(spike), 0);
    while (!update_done) @(negedge clk);
    model(0, 0, 0);

    // R9 rounding
    wr(4, 16'h0080);
    step(16'h0001, 16'h0000, 16'h0000, 1'b0, n);
    chk("R9 round half up", s16(gex_out), 1);
    step(16'hFFFD, 16'h0000, 16'h0000, 1'b0, n);
    chk("R9 round negative", s16(gex_out), -1);

    // R9 saturation
    wr(4, 16'h0100); wr(1, 16'h7FFF); wr(6, 16'h0000); wr(3, 16'h7FFF);
    step(16'h7FFF, 16'h0000, 16'h0000, 1'b0, n);
    step(16'h7FFF, 16'h0000, 16'h0000, 1'b0, n);
    chk("R9 gex saturated", s16(gex_out), 32767);
    chk("R9 v saturated", s16(v_out), 32767);
    check_state("R9 model");

    // R8 start while busy ignored
    wr(4, 16'h0080); wr(1, 16'h0100); wr(3, 16'h0400);
    step(16'h0100, 16'h0000, 16'h0000, 1'b1, n);
    repeat (8) @(negedge clk);
    chk("R8 busy start ignored busy", int'(busy), 0);
    check_state("R8 busy start ignored");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule